// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller sits between a bank of level-sensitive interrupt sources and a processor that has two request inputs, a normal one and a fast one. Source 0 is the fast source and drives the fast request line directly. Every other source takes part in priority resolution and drives the normal request line. Each source has an enable bit, a 3-bit priority and a vector. Software reads a vector register to learn which interrupt to service. That read pushes the winning source onto a nesting stack, and an end-of-interrupt command pops it again.

A read that finds nothing to service returns a programmable spurious vector. It also places the controller in a spurious state, in which both request lines stay low until an end-of-interrupt command arrives. A protect-mode input allows a debugger to read the vector register without side effects. In that mode the outcome seen at the read is latched, and it is applied only when software later writes any value to the vector register.

Register map (word index on `reg_addr_i`): 0 vector (read and, in protect mode, write), 1 fast vector (read), 2 status (read, current interrupt number in bits 4:0, 0 when the stack is empty), 3 enable set (write), 4 enable clear (write), 5 end of interrupt (write), 6 spurious vector (read/write), 7 enable mask (read), 8 source configuration (write: source number in bits 4:0, priority in bits 10:8, vector in bits 31:16).

Top module: `vic_core`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, status reads 0, the enable mask reads 0 and the nesting stack is empty.
- R2: A write to enable set ORs the write data into the enable mask, and a write to enable clear clears the bits that are set in the write data. A disabled source never asserts a request line and never wins priority resolution.
- R3: Among the enabled, pending sources 1 and up, the source with the highest priority wins, and a tie goes to the lower source number. `irq_o` is high only when the winner's priority is strictly greater than the priority on top of the stack, or when the stack is empty.
- R4: In normal mode, a vector read while `irq_o` could be high returns the winner's vector in the same cycle, pushes the winner onto the stack, and makes status report the winner's number from the next cycle on.
- R5: A vector read with no eligible winner returns the spurious vector and enters the spurious state. A fast-vector read while source 0 is not both pending and enabled does the same. In protect mode, neither read has any side effect.
- R6: While the controller is in the spurious state, `irq_o` and `fiq_o` are both low, whatever the sources do.
- R7: When the controller is not in the spurious state, an end-of-interrupt write pops the stack and restores the previous status and level. When it is in the spurious state, the write only leaves that state and the stack is unchanged.
- R8: When `prot_en_i` is 1, a vector read returns the same data as in normal mode but changes neither the stack nor status. A following vector write applies the outcome latched at that read (a push of the latched source, or entry into the spurious state), even if the sources have changed in between. In normal mode, a vector write is ignored.
- R9: `fiq_o` is high when source 0 is both pending and enabled. A fast-vector read then returns source 0's vector. Source 0 never drives `irq_o`.
- R10: The stack nests up to 8 levels, one for each priority. With all 8 levels in use, no further interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt sources; bit 0 is the fast source |
| prot_en_i | input | 1 | Protect mode enable |
| reg_addr_i | input | 4 | Register word index |
| reg_rd_i | input | 1 | Register read strobe; side effects occur on the clock edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address and the current state |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is protect mode when the sources change between the quiet read and the committing write. In that case the pushed source must be the latched one and not the current winner. The bench raises a low-priority source, reads in protect mode, then switches the sources to a single higher-priority one before it writes. It also drives a full eight-level nest by raising one source per priority level in ascending order. It mixes the spurious state with a non-empty stack, so that it can show that the end-of-interrupt write which clears the spurious state does not pop.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W       = 4;
  localparam int CFG_PRIO_LSB = 8;
  localparam int CFG_VEC_LSB  = 16;

  localparam logic [ADDR_W-1:0] A_VEC    = 4'd0;
  localparam logic [ADDR_W-1:0] A_FVEC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_EN_SET = 4'd3;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_EOI    = 4'd5;
  localparam logic [ADDR_W-1:0] A_SPUR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_EN     = 4'd7;
  localparam logic [ADDR_W-1:0] A_CFG    = 4'd8;
endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [NUM_SRC-1:0]                  en_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]      prio_o,
  output logic [NUM_SRC-1:0][VEC_W-1:0]       vec_o,
  output logic [VEC_W-1:0]                    spur_vec_o
);
  localparam int ID_W = $clog2(NUM_SRC);

  logic [ID_W-1:0]   cfg_id;
  logic [PRIO_W-1:0] cfg_prio;
  logic [VEC_W-1:0]  cfg_vec;

  assign cfg_id   = wdata_i[ID_W-1:0];
  assign cfg_prio = wdata_i[CFG_PRIO_LSB +: PRIO_W];
  assign cfg_vec  = wdata_i[CFG_VEC_LSB +: VEC_W];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= '0;
      spur_vec_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_EN_SET: en_o       <= en_o | wdata_i[NUM_SRC-1:0];
        A_EN_CLR: en_o       <= en_o & ~wdata_i[NUM_SRC-1:0];
        A_SPUR:   spur_vec_o <= wdata_i[VEC_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= '0;
        vec_o[g]  <= '0;
      end else if (wr_i && addr_i == A_CFG && int'(cfg_id) == g) begin
        prio_o[g] <= cfg_prio;
        vec_o[g]  <= cfg_vec;
      end
    end
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           vld_o,
  output logic [ID_W-1:0]                id_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // Source 0 is the fast path; strict compare keeps the lower index on ties
  always_comb begin
    logic              v;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] p;
    v  = 1'b0;
    id = '0;
    p  = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (req_i[i] && (!v || prio_i[i] > p)) begin
        v  = 1'b1;
        id = ID_W'(i);
        p  = prio_i[i];
      end
    end
    vld_o  = v;
    id_o   = id;
    prio_o = p;
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [ID_W-1:0]   push_id_i,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [ID_W-1:0]   top_id_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [SP_W-1:0]   depth_o
);
  logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
  logic [DEPTH-1:0][ID_W-1:0]   id_q;
  logic [SP_W-1:0]              sp_q;
  logic [SP_W-1:0]              sp_m1;

  assign sp_m1   = sp_q - SP_W'(1);
  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign depth_o = sp_q;

  assign top_prio_o = empty_o ? '0 : prio_q[sp_m1[IDX_W-1:0]];
  assign top_id_o   = empty_o ? '0 : id_q[sp_m1[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      prio_q <= '0;
      id_q   <= '0;
    end else if (push_i && !full_o) begin
      prio_q[sp_q[IDX_W-1:0]] <= push_prio_i;
      id_q[sp_q[IDX_W-1:0]]   <= push_id_i;
      sp_q                    <= sp_q + SP_W'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_m1;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R3
  nest_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |-> (push_prio_i > top_prio_o));
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 16,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              prot_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int ID_W = $clog2(NUM_SRC);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [NUM_SRC-1:0]             en;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0][VEC_W-1:0]  vec;
  logic [VEC_W-1:0]               spur_vec;

  vic_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) cfg_i (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .prio_o(prio), .vec_o(vec), .spur_vec_o(spur_vec));

  logic              win_vld;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_prio;

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .req_i(src_i & en), .prio_i(prio), .vld_o(win_vld), .id_o(win_id), .prio_o(win_prio));

  logic              push, pop;
  logic [PRIO_W-1:0] push_prio, top_prio;
  logic [ID_W-1:0]   push_id, top_id;
  logic              stk_empty, stk_full;
  logic [SP_W-1:0]   depth;

  vic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W)) stk_i (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .push_prio_i(push_prio), .push_id_i(push_id),
    .top_prio_o(top_prio), .top_id_o(top_id), .empty_o(stk_empty), .full_o(stk_full),
    .depth_o(depth));

  logic              spur_q;
  logic              lat_vld_q, lat_hit_q;
  logic [ID_W-1:0]   lat_id_q;
  logic [PRIO_W-1:0] lat_prio_q;

  logic cand_ok, fast_act, lat_ok;
  logic vec_rd, fvec_rd, vec_wr, eoi_wr, spur_set;

  assign cand_ok  = win_vld && !stk_full && (stk_empty || win_prio > top_prio);
  assign fast_act = src_i[0] && en[0];
  assign irq_o    = cand_ok && !spur_q;
  assign fiq_o    = fast_act && !spur_q;

  assign vec_rd  = reg_rd_i && reg_addr_i == A_VEC;
  assign fvec_rd = reg_rd_i && reg_addr_i == A_FVEC;
  assign vec_wr  = reg_wr_i && reg_addr_i == A_VEC;
  assign eoi_wr  = reg_wr_i && reg_addr_i == A_EOI;

  // Latched protect-mode push is dropped if the stack moved past it meanwhile
  assign lat_ok = lat_hit_q && !stk_full && (stk_empty || lat_prio_q > top_prio);

  always_comb begin
    push      = 1'b0;
    push_id   = win_id;
    push_prio = win_prio;
    spur_set  = 1'b0;
    if (!prot_en_i) begin
      push     = vec_rd && cand_ok;
      spur_set = (vec_rd && !cand_ok) || (fvec_rd && !fast_act);
    end else if (vec_wr && lat_vld_q) begin
      push      = lat_ok;
      push_id   = lat_id_q;
      push_prio = lat_prio_q;
      spur_set  = !lat_hit_q;
    end
  end

  assign pop = eoi_wr && !spur_q && !stk_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spur_q     <= 1'b0;
      lat_vld_q  <= 1'b0;
      lat_hit_q  <= 1'b0;
      lat_id_q   <= '0;
      lat_prio_q <= '0;
    end else begin
      if (eoi_wr)        spur_q <= 1'b0;
      else if (spur_set) spur_q <= 1'b1;
      if (prot_en_i && vec_rd) begin
        lat_vld_q  <= 1'b1;
        lat_hit_q  <= cand_ok;
        lat_id_q   <= win_id;
        lat_prio_q <= win_prio;
      end else if (vec_wr) begin
        lat_vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_VEC:  reg_rdata_o = DATA_W'(cand_ok ? vec[win_id] : spur_vec);
      A_FVEC: reg_rdata_o = DATA_W'(fast_act ? vec[0] : spur_vec);
      A_STAT: reg_rdata_o = DATA_W'(top_id);
      A_EN:   reg_rdata_o = DATA_W'(en);
      A_SPUR: reg_rdata_o = DATA_W'(spur_vec);
      default: ;
    endcase
  end

  // R6
  spur_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_q |-> (!irq_o && !fiq_o));
  // R8
  prot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_i && reg_rd_i && !reg_wr_i) |=> ($stable(depth) && $stable(top_id)));
  // R7
  spur_eoi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && spur_q) |=> (!spur_q && $stable(depth)));
endmodule

// File: tb/vic_core_tb.sv
module vic_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        prot = 1'b0;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_chk = 0, n_err = 0;
  int pr[32];
  logic [31:0] d;

  localparam logic [3:0] VEC = 0, FVEC = 1, STAT = 2, ESET = 3, ECLR = 4,
                         EOI = 5, SPUR = 6, EN = 7, CFG = 8;
  localparam logic [31:0] SPV = 32'h0000_DEAD;

  always #4 clk = ~clk;

  vic_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .prot_en_i(prot), .reg_addr_i(addr),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq));

  function automatic logic [31:0] vx(int i);
    return 32'h100 + 32'(i) * 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk); src = s; #1;
  endtask

  task automatic cfg(input int i, input int p);
    pr[i] = p;
    wr_reg(CFG, {vx(i)[15:0], 5'd0, 3'(p), 3'd0, 5'(i)});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1 irq", 32'(irq), 0); chk("R1 fiq", 32'(fiq), 0);
    rd_reg(STAT, d); chk("R1 status", d, 0);
    rd_reg(EN, d);   chk("R1 enable", d, 0);

    // R2 enable set/clear
    wr_reg(ESET, 32'h0000_00F0); wr_reg(ECLR, 32'h0000_0030);
    rd_reg(EN, d); chk("R2 mask", d, 32'h0000_00C0);
    wr_reg(ESET, 32'hFFFF_FFFF);
    rd_reg(EN, d); chk("R2 all", d, 32'hFFFF_FFFF);

    wr_reg(SPUR, SPV); rd_reg(SPUR, d); chk("R5 spur reg", d, SPV);
    for (int i = 0; i < 32; i++) cfg(i, (i * 5) % 8);

    // R3/R4 sweep over every pair of priority sources
    for (int a = 1; a < 32; a++) begin
      for (int b = a; b < 32; b++) begin
        int w;
        w = (pr[b] > pr[a]) ? b : a;
        set_src((32'd1 << a) | (32'd1 << b));
        chk("R3 irq", 32'(irq), 1);
        rd_reg(VEC, d); chk("R4 vector", d, vx(w));
        rd_reg(STAT, d); chk("R4 status", d, 32'(w));
        wr_reg(EOI, 0);
        rd_reg(STAT, d); chk("R7 pop", d, 0);
      end
    end
    set_src(0);

    // R2 disabled source loses and does not raise
    set_src((32'd1 << 3) | (32'd1 << 11));
    wr_reg(ECLR, 32'd1 << 3);
    rd_reg(VEC, d); chk("R2 disabled loses", d, vx(11));
    wr_reg(EOI, 0); wr_reg(ESET, 32'd1 << 3);
    set_src(32'd1 << 5); wr_reg(ECLR, 32'd1 << 5); #1;
    chk("R2 disabled irq", 32'(irq), 0);
    rd_reg(VEC, d); chk("R2 disabled spurious", d, SPV);
    wr_reg(EOI, 0); wr_reg(ESET, 32'd1 << 5); set_src(0);

    // R10 full nest: source k gets priority k-1
    for (int k = 1; k <= 8; k++) cfg(k, k - 1);
    begin
      logic [31:0] s;
      s = 0;
      for (int k = 1; k <= 8; k++) begin
        s |= 32'd1 << k;
        set_src(s);
        chk("R10 irq", 32'(irq), 1);
        rd_reg(VEC, d); chk("R10 vector", d, vx(k));
        rd_reg(STAT, d); chk("R10 status", d, 32'(k));
      end
      chk("R10 full no irq", 32'(irq), 0);
      set_src(s | (32'd1 << 9));
      chk("R3 no higher", 32'(irq), 0);
      for (int k = 8; k >= 1; k--) begin
        wr_reg(EOI, 0);
        rd_reg(STAT, d); chk("R7 restore", d, 32'(k - 1));
      end
      #1 chk("R7 rearm", 32'(irq), 1);
    end
    set_src(0);

    // R3 equal priority does not nest (src6 prio5, src9 prio5)
    set_src(32'd1 << 6); rd_reg(VEC, d);
    set_src((32'd1 << 6) | (32'd1 << 9));
    chk("R3 strict", 32'(irq), 0);

    // R5/R6/R7 spurious with a non-empty stack
    rd_reg(VEC, d); chk("R5 spurious", d, SPV);
    set_src((32'd1 << 6) | (32'd1 << 8) | 32'd1);
    chk("R6 irq masked", 32'(irq), 0); chk("R6 fiq masked", 32'(fiq), 0);
    wr_reg(EOI, 0); #1;
    chk("R6 fiq back", 32'(fiq), 1); chk("R6 irq back", 32'(irq), 1);
    rd_reg(STAT, d); chk("R7 spurious no pop", d, 6);
    wr_reg(EOI, 0);
    rd_reg(STAT, d); chk("R7 pop", d, 0);

    // R9 fast path
    set_src(32'd1); #1;
    chk("R9 fiq", 32'(fiq), 1); chk("R9 no irq", 32'(irq), 0);
    rd_reg(FVEC, d); chk("R9 fast vector", d, vx(0));
    set_src(0);
    rd_reg(FVEC, d); chk("R5 fast spurious", d, SPV);
    set_src(32'd1 << 4); chk("R5 fast spurious masks", 32'(irq), 0);
    wr_reg(EOI, 0); #1 chk("R7 clear", 32'(irq), 1);
    set_src(0);

    // R8 protect mode
    prot = 1'b1;
    set_src(32'd1 << 2);
    rd_reg(VEC, d); chk("R8 read vector", d, vx(2));
    rd_reg(STAT, d); chk("R8 read quiet", d, 0);
    #1 chk("R8 irq still", 32'(irq), 1);
    set_src(32'd1 << 7);
    wr_reg(VEC, 32'h1234);
    rd_reg(STAT, d); chk("R8 latched push", d, 2);
    rd_reg(VEC, d); chk("R8 second read", d, vx(7));
    wr_reg(VEC, 0);
    rd_reg(STAT, d); chk("R8 second push", d, 7);
    wr_reg(EOI, 0); wr_reg(EOI, 0);
    rd_reg(STAT, d); chk("R8 unwound", d, 0);
    set_src(0);
    rd_reg(VEC, d); chk("R8 spurious read", d, SPV);
    set_src(32'd1 << 2); chk("R8 read no spurious", 32'(irq), 1);
    wr_reg(VEC, 0); #1 chk("R8 write spurious", 32'(irq), 0);
    wr_reg(EOI, 0);
    prot = 1'b0;
    wr_reg(VEC, 0);
    rd_reg(STAT, d); chk("R8 normal write ignored", d, 0);
    #1 chk("R8 normal write irq", 32'(irq), 1);

    finish_run();
  end
endmodule